// File: doc/BRIEF.md
# Ping-Pong Readout Trigger Router

This block steers first-level trigger accepts across a set of interleaved readout banks (two by default) that digitize copies of the same split detector signal. None of the banks is pipelined. The aim is to keep the front end live at high first-level rates. Each accept goes to the lowest-numbered idle bank, which opens its gate and is marked busy. The bank then holds its event until a second-level decision arrives or a programmable timeout expires.

A second-level reject, or a timeout, sends that bank into a fast-clear phase of programmable length. A second-level accept moves the bank into conversion, which lasts until the bank's own conversion-done input is seen. Decisions are always applied to the bank holding the oldest pending event, whatever its index. The global front-end busy output rises only when every bank is occupied. A first-level accept that arrives while all banks are occupied is dropped and counted. Three counters (accepted, cleared, dropped) let a bench measure dead time.

Top module: `pingpong_trig_router`

## Requirements
- R1: While reset is asserted and right after it, every bank is idle: all gate, clear, conversion and busy outputs are 0, front-end busy is 0 and all three counters are 0.
- R2: A first-level accept sampled while at least one bank is idle makes the lowest-numbered idle bank raise its gate and busy outputs from the next cycle on. The gate stays high for GATE_LEN cycles (default 4) and then falls while busy stays high.
- R3: Front-end busy is 1 exactly when every bank's busy output is 1.
- R4: A first-level accept sampled while every bank is busy is dropped: no bank output changes because of it, and the drop counter rises by one on the next cycle.
- R5: A second-level decision is applied to the bank whose pending event (gated or waiting) is oldest, even when a newer pending event sits in a lower-numbered bank.
- R6: A second-level decision with pass=1 ends the bank's gate and starts conversion from the next cycle, and raises the accept counter by one. Conversion stays high until the bank's conversion-done input is sampled high; the bank is idle from the following cycle.
- R7: A second-level decision with pass=0 raises the bank's clear output from the next cycle for clear_cycles cycles (a value of 0 acts as 1), raises the clear counter by one, and leaves the bank idle afterwards.
- R8: A bank whose event gets no second-level decision within l2_tmo_cycles cycles, counted from its first gate cycle, enters the clear phase of R7 in the cycle after the last allowed one. The clear counter rises by one.
- R9: A second-level decision while no bank holds a pending event is ignored: no bank output and no counter changes.
- R10: A second-level decision sampled in the same cycle in which the oldest bank's timeout expires takes precedence over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l1_accept | input | 1 | First-level trigger accept, one cycle per trigger |
| l2_valid | input | 1 | Second-level decision strobe |
| l2_pass | input | 1 | Second-level decision value, 1 accept, 0 reject |
| l2_tmo_cycles | input | TMO_W | Maximum cycles an event may wait for a decision |
| clr_cycles | input | CLR_W | Fast-clear duration in cycles |
| conv_done | input | NB | Per-bank end of conversion |
| bank_gate | output | NB | Per-bank gate to the digitizers |
| bank_clear | output | NB | Per-bank fast clear |
| bank_conv | output | NB | Per-bank conversion and readout in progress |
| bank_busy | output | NB | Per-bank occupied flag |
| fe_busy | output | 1 | All banks occupied |
| cnt_accept | output | CNT_W | Events accepted at second level |
| cnt_clear | output | CNT_W | Events fast-cleared (reject or timeout) |
| cnt_drop | output | CNT_W | First-level triggers lost to full occupancy |

## Verification
The timing properties assume that l2_tmo_cycles and clr_cycles change only while every bank is idle. The timeout window and clear length are checked against the current values, and the oldest-first expiry order depends on a fixed timeout. The decision and conversion-done strobes are taken as single-cycle pulses, and conversion-done is assumed to be raised only for a converting bank. The stimulus writes both configuration values only between scenarios, after all banks have returned to idle. It pulses each strobe for exactly one cycle, and it raises conversion-done only for the bank that is converting.

// File: rtl/trig_router_pkg.sv
package trig_router_pkg;

  typedef enum logic [2:0] {
    BK_IDLE  = 3'd0,
    BK_GATED = 3'd1,
    BK_WAIT  = 3'd2,
    BK_CLEAR = 3'd3,
    BK_CONV  = 3'd4
  } bank_state_e;

endpackage

// File: rtl/trig_bank_fsm.sv
module trig_bank_fsm
  import trig_router_pkg::*;
#(
  parameter int GATE_LEN = 4,
  parameter int TMO_W    = 12,
  parameter int CLR_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             decide,
  input  logic             pass,
  input  logic [TMO_W-1:0] tmo_cycles,
  input  logic [CLR_W-1:0] clr_cycles,
  input  logic             conv_done,
  output logic             gate,
  output logic             clear,
  output logic             conv,
  output logic             busy,
  output logic             leave,
  output logic             took_accept,
  output logic             took_clear
);

  localparam int TW = (TMO_W > CLR_W) ? TMO_W : CLR_W;
  localparam int XW = TW + 1;

  bank_state_e st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;
  logic [XW-1:0] tmr_inc, tmo_x, clr_x;
  logic          tmo_hit, clr_end, gate_end;

  assign tmr_inc  = XW'(tmr_q) + XW'(1);
  assign tmo_x    = XW'(tmo_cycles);
  assign clr_x    = XW'(clr_cycles);
  assign tmo_hit  = (tmr_inc >= tmo_x);
  assign clr_end  = (tmr_inc >= clr_x);
  assign gate_end = (tmr_q == TW'(GATE_LEN - 1));

  always_comb begin
    st_d        = st_q;
    tmr_d       = tmr_q;
    tmr_en      = 1'b0;
    leave       = 1'b0;
    took_accept = 1'b0;
    took_clear  = 1'b0;
    case (st_q)
      BK_IDLE: begin
        if (start) begin
          st_d   = BK_GATED;
          tmr_d  = '0;
          tmr_en = 1'b1;
        end
      end
      BK_GATED, BK_WAIT: begin
        if (decide) begin
          leave  = 1'b1;
          tmr_d  = '0;
          tmr_en = 1'b1;
          if (pass) begin
            st_d        = BK_CONV;
            took_accept = 1'b1;
          end else begin
            st_d       = BK_CLEAR;
            took_clear = 1'b1;
          end
        end else if (tmo_hit) begin
          leave      = 1'b1;
          st_d       = BK_CLEAR;
          took_clear = 1'b1;
          tmr_d      = '0;
          tmr_en     = 1'b1;
        end else begin
          tmr_d  = tmr_q + TW'(1);
          tmr_en = 1'b1;
          if ((st_q == BK_GATED) && gate_end) begin
            st_d = BK_WAIT;
          end
        end
      end
      BK_CLEAR: begin
        if (clr_end) begin
          st_d = BK_IDLE;
        end else begin
          tmr_d  = tmr_q + TW'(1);
          tmr_en = 1'b1;
        end
      end
      BK_CONV: begin
        if (conv_done) begin
          st_d = BK_IDLE;
        end
      end
      default: st_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      tmr_q <= '0;
    end else begin
      st_q <= st_d;
      if (tmr_en) begin
        tmr_q <= tmr_d;
      end
    end
  end

  assign gate  = (st_q == BK_GATED);
  assign clear = (st_q == BK_CLEAR);
  assign conv  = (st_q == BK_CONV);
  assign busy  = (st_q != BK_IDLE);

endmodule

// File: rtl/trig_order_queue.sv
module trig_order_queue #(
  parameter int NB = 2,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_id,
  input  logic          pop,
  output logic [IW-1:0] head_id,
  output logic          head_valid
);

  localparam int CW = $clog2(NB + 1);

  logic [IW-1:0] slot_q [NB];
  logic [IW-1:0] slot_d [NB];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          q_en;

  assign q_en = push | pop;

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      slot_d[k] = slot_q[k];
    end
    cnt_d = cnt_q;
    if (pop && (cnt_q != '0)) begin
      for (int k = 0; k < NB - 1; k++) begin
        slot_d[k] = slot_q[k+1];
      end
      cnt_d = cnt_q - CW'(1);
    end
    if (push && (cnt_d < CW'(NB))) begin
      for (int k = 0; k < NB; k++) begin
        if (cnt_d == CW'(k)) begin
          slot_d[k] = push_id;
        end
      end
      cnt_d = cnt_d + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int k = 0; k < NB; k++) begin
        slot_q[k] <= '0;
      end
    end else if (q_en) begin
      cnt_q <= cnt_d;
      for (int k = 0; k < NB; k++) begin
        slot_q[k] <= slot_d[k];
      end
    end
  end

  assign head_id    = slot_q[0];
  assign head_valid = (cnt_q != '0);

endmodule

// File: rtl/trig_steer.sv
module trig_steer #(
  parameter int NB = 2,
  parameter int IW = 1
) (
  input  logic [NB-1:0] idle,
  output logic [NB-1:0] grant,
  output logic [IW-1:0] grant_id,
  output logic          any_idle
);

  always_comb begin
    grant    = '0;
    grant_id = '0;
    any_idle = 1'b0;
    for (int k = 0; k < NB; k++) begin
      if (idle[k] && !any_idle) begin
        grant[k] = 1'b1;
        grant_id = IW'(k);
        any_idle = 1'b1;
      end
    end
  end

endmodule

// File: rtl/trig_tally.sv
module trig_tally #(
  parameter int NCNT  = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCNT-1:0]  inc,
  output logic [CNT_W-1:0] count [NCNT]
);

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    logic [CNT_W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (inc[k]) begin
        val_q <= val_q + CNT_W'(1);
      end
    end

    assign count[k] = val_q;
  end

endmodule

// File: rtl/pingpong_trig_router.sv
module pingpong_trig_router
  import trig_router_pkg::*;
#(
  parameter int NB       = 2,
  parameter int GATE_LEN = 4,
  parameter int TMO_W    = 12,
  parameter int CLR_W    = 12,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             l1_accept,
  input  logic             l2_valid,
  input  logic             l2_pass,
  input  logic [TMO_W-1:0] l2_tmo_cycles,
  input  logic [CLR_W-1:0] clr_cycles,
  input  logic [NB-1:0]    conv_done,
  output logic [NB-1:0]    bank_gate,
  output logic [NB-1:0]    bank_clear,
  output logic [NB-1:0]    bank_conv,
  output logic [NB-1:0]    bank_busy,
  output logic             fe_busy,
  output logic [CNT_W-1:0] cnt_accept,
  output logic [CNT_W-1:0] cnt_clear,
  output logic [CNT_W-1:0] cnt_drop
);

  localparam int IW   = (NB > 1) ? $clog2(NB) : 1;
  localparam int NCNT = 3;

  logic [NB-1:0]    grant, start, decide, leave, took_acc, took_clr;
  logic [IW-1:0]    grant_id, head_id;
  logic             any_idle, head_valid, drop;
  logic [NCNT-1:0]  tally_inc;
  logic [CNT_W-1:0] tally_cnt [NCNT];

  trig_steer #(.NB(NB), .IW(IW)) i_steer (
    .idle     (~bank_busy),
    .grant    (grant),
    .grant_id (grant_id),
    .any_idle (any_idle)
  );

  assign drop = l1_accept & ~any_idle;

  trig_order_queue #(.NB(NB), .IW(IW)) i_order (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (l1_accept & any_idle),
    .push_id    (grant_id),
    .pop        (|leave),
    .head_id    (head_id),
    .head_valid (head_valid)
  );

  for (genvar i = 0; i < NB; i++) begin : g_bank
    assign start[i]  = l1_accept & grant[i];
    assign decide[i] = l2_valid & head_valid & (head_id == IW'(i));

    trig_bank_fsm #(
      .GATE_LEN (GATE_LEN),
      .TMO_W    (TMO_W),
      .CLR_W    (CLR_W)
    ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start[i]),
      .decide      (decide[i]),
      .pass        (l2_pass),
      .tmo_cycles  (l2_tmo_cycles),
      .clr_cycles  (clr_cycles),
      .conv_done   (conv_done[i]),
      .gate        (bank_gate[i]),
      .clear       (bank_clear[i]),
      .conv        (bank_conv[i]),
      .busy        (bank_busy[i]),
      .leave       (leave[i]),
      .took_accept (took_acc[i]),
      .took_clear  (took_clr[i])
    );
  end

  assign tally_inc = {drop, |took_clr, |took_acc};

  trig_tally #(.NCNT(NCNT), .CNT_W(CNT_W)) i_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (tally_inc),
    .count (tally_cnt)
  );

  assign cnt_accept = tally_cnt[0];
  assign cnt_clear  = tally_cnt[1];
  assign cnt_drop   = tally_cnt[2];
  assign fe_busy    = &bank_busy;

endmodule

// File: rtl/pingpong_trig_router_chk.sv
module pingpong_trig_router_chk #(
  parameter int NB    = 2,
  parameter int TMO_W = 12,
  parameter int CLR_W = 12,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             l1_accept,
  input logic             l2_valid,
  input logic             l2_pass,
  input logic [TMO_W-1:0] l2_tmo_cycles,
  input logic [CLR_W-1:0] clr_cycles,
  input logic [NB-1:0]    conv_done,
  input logic [NB-1:0]    bank_gate,
  input logic [NB-1:0]    bank_clear,
  input logic [NB-1:0]    bank_conv,
  input logic [NB-1:0]    bank_busy,
  input logic             fe_busy,
  input logic [CNT_W-1:0] cnt_accept,
  input logic [CNT_W-1:0] cnt_clear,
  input logic [CNT_W-1:0] cnt_drop
);

  logic [NB-1:0]    pending;
  logic [NB-1:0]    lower_busy;
  logic [TMO_W:0]   tmo_lim;
  logic [CLR_W:0]   clr_lim;

  assign pending = bank_busy & ~bank_clear & ~bank_conv;
  assign tmo_lim = (l2_tmo_cycles == '0) ? (TMO_W+1)'(1) : (TMO_W+1)'(l2_tmo_cycles);
  assign clr_lim = (clr_cycles == '0) ? (CLR_W+1)'(1) : (CLR_W+1)'(clr_cycles);

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      lower_busy[i] = 1'b1;
      for (int j = 0; j < i; j++) begin
        lower_busy[i] = lower_busy[i] & bank_busy[j];
      end
    end
  end

  // R2: one new gate per routed trigger
  p_one_new_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_accept && !fe_busy) |=> ($countones(bank_gate & ~$past(bank_gate)) == 1));

  // R3: busy can only become global through a new trigger
  p_fe_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_busy) |-> $past(l1_accept));

  // R4: dropped trigger is counted
  p_drop_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_accept && fe_busy) |=> (cnt_drop == $past(cnt_drop) + CNT_W'(1)));

  // R9: decision without a pending event leaves counters alone
  p_idle_decision_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_valid && (pending == '0)) |=> ($stable(cnt_accept) && $stable(cnt_clear)));

  for (genvar i = 0; i < NB; i++) begin : g_chk
    logic [CLR_W:0] clr_run;
    logic [TMO_W:0] pend_run;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        clr_run  <= '0;
        pend_run <= '0;
      end else begin
        clr_run  <= bank_clear[i] ? clr_run + (CLR_W+1)'(1) : '0;
        pend_run <= pending[i] ? pend_run + (TMO_W+1)'(1) : '0;
      end
    end

    // R2: lowest idle bank receives the trigger
    p_route_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_accept && !bank_busy[i] && lower_busy[i]) |=> bank_gate[i]);

    // R6: conversion only follows a pass decision
    p_conv_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_conv[i]) |-> $past(l2_valid && l2_pass));

    // R6: conversion ends only on conversion-done
    p_conv_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_conv[i]) |-> $past(conv_done[i]));

    // R7: clear lasts no longer than programmed
    p_clear_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bank_clear[i] |-> (clr_run < clr_lim));

    // R8: no event is held past the timeout window
    p_pend_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pending[i] |-> (pend_run < tmo_lim));
  end

endmodule

bind pingpong_trig_router pingpong_trig_router_chk #(
  .NB    (NB),
  .TMO_W (TMO_W),
  .CLR_W (CLR_W),
  .CNT_W (CNT_W)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .l1_accept     (l1_accept),
  .l2_valid      (l2_valid),
  .l2_pass       (l2_pass),
  .l2_tmo_cycles (l2_tmo_cycles),
  .clr_cycles    (clr_cycles),
  .conv_done     (conv_done),
  .bank_gate     (bank_gate),
  .bank_clear    (bank_clear),
  .bank_conv     (bank_conv),
  .bank_busy     (bank_busy),
  .fe_busy       (fe_busy),
  .cnt_accept    (cnt_accept),
  .cnt_clear     (cnt_clear),
  .cnt_drop      (cnt_drop)
);

// File: tb/test_pingpong_trig_router.sv
module test_pingpong_trig_router;

  localparam int NB    = 2;
  localparam int TMO_W = 12;
  localparam int CLR_W = 12;
  localparam int CNT_W = 16;

  logic             clk;
  logic             rst_n;
  logic             l1_accept;
  logic             l2_valid;
  logic             l2_pass;
  logic [TMO_W-1:0] l2_tmo_cycles;
  logic [CLR_W-1:0] clr_cycles;
  logic [NB-1:0]    conv_done;
  logic [NB-1:0]    bank_gate, bank_clear, bank_conv, bank_busy;
  logic             fe_busy;
  logic [CNT_W-1:0] cnt_accept, cnt_clear, cnt_drop;

  int total = 0;
  int bad   = 0;
  int exp_acc = 0;
  int exp_clr = 0;
  int exp_drp = 0;

  pingpong_trig_router i_pingpong_trig_router (
    .clk           (clk),
    .rst_n         (rst_n),
    .l1_accept     (l1_accept),
    .l2_valid      (l2_valid),
    .l2_pass       (l2_pass),
    .l2_tmo_cycles (l2_tmo_cycles),
    .clr_cycles    (clr_cycles),
    .conv_done     (conv_done),
    .bank_gate     (bank_gate),
    .bank_clear    (bank_clear),
    .bank_conv     (bank_conv),
    .bank_busy     (bank_busy),
    .fe_busy       (fe_busy),
    .cnt_accept    (cnt_accept),
    .cnt_clear     (cnt_clear),
    .cnt_drop      (cnt_drop)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic chk_banks(input string req, input logic [1:0] g, input logic [1:0] c,
                           input logic [1:0] v, input logic [1:0] b);
    chk({req, " gate"},    32'(bank_gate),  32'(g));
    chk({req, " clear"},   32'(bank_clear), 32'(c));
    chk({req, " conv"},    32'(bank_conv),  32'(v));
    chk({req, " busy"},    32'(bank_busy),  32'(b));
    chk({req, " fe_busy"}, 32'(fe_busy),    32'(&b));
  endtask

  task automatic chk_cnts(input string req);
    chk({req, " cnt_accept"}, 32'(cnt_accept), 32'(exp_acc));
    chk({req, " cnt_clear"},  32'(cnt_clear),  32'(exp_clr));
    chk({req, " cnt_drop"},   32'(cnt_drop),   32'(exp_drp));
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_l1();
    l1_accept = 1'b1;
    @(negedge clk);
    l1_accept = 1'b0;
  endtask

  task automatic pulse_l2(input logic pass);
    l2_valid = 1'b1;
    l2_pass  = pass;
    @(negedge clk);
    l2_valid = 1'b0;
    l2_pass  = 1'b0;
  endtask

  task automatic pulse_done(input logic [1:0] m);
    conv_done = m;
    @(negedge clk);
    conv_done = '0;
  endtask

  task automatic t_reset();
    chk_banks("R1 in reset", 2'b00, 2'b00, 2'b00, 2'b00);
    chk_cnts("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    tick(2);
    chk_banks("R1 after reset", 2'b00, 2'b00, 2'b00, 2'b00);
    chk_cnts("R1 after reset");
  endtask

  task automatic t_accept();
    l2_tmo_cycles = 200; clr_cycles = 5;
    pulse_l1();
    chk_banks("R2 first gate", 2'b01, 2'b00, 2'b00, 2'b01);
    tick(3);
    chk_banks("R2 last gate cycle", 2'b01, 2'b00, 2'b00, 2'b01);
    tick(1);
    chk_banks("R2 gate closed", 2'b00, 2'b00, 2'b00, 2'b01);
    pulse_l2(1'b1);
    exp_acc++;
    chk_banks("R6 conversion start", 2'b00, 2'b00, 2'b01, 2'b01);
    chk_cnts("R6 accept counted");
    tick(5);
    chk_banks("R6 conversion held", 2'b00, 2'b00, 2'b01, 2'b01);
    pulse_done(2'b01);
    chk_banks("R6 conversion done", 2'b00, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic t_reject();
    l2_tmo_cycles = 200; clr_cycles = 5;
    pulse_l1();
    tick(1);
    pulse_l2(1'b0);
    exp_clr++;
    chk_banks("R7 clear start during gate", 2'b00, 2'b01, 2'b00, 2'b01);
    chk_cnts("R7 clear counted");
    tick(4);
    chk_banks("R7 clear last cycle", 2'b00, 2'b01, 2'b00, 2'b01);
    tick(1);
    chk_banks("R7 clear ended", 2'b00, 2'b00, 2'b00, 2'b00);
    clr_cycles = 0;
    pulse_l1();
    pulse_l2(1'b0);
    exp_clr++;
    chk_banks("R7 zero length clear", 2'b00, 2'b01, 2'b00, 2'b01);
    tick(1);
    chk_banks("R7 zero length acts as one", 2'b00, 2'b00, 2'b00, 2'b00);
    chk_cnts("R7 zero length counters");
  endtask

  task automatic t_timeout();
    l2_tmo_cycles = 20; clr_cycles = 5;
    pulse_l1();
    tick(19);
    chk_banks("R8 last allowed wait cycle", 2'b00, 2'b00, 2'b00, 2'b01);
    chk_cnts("R8 before timeout");
    tick(1);
    exp_clr++;
    chk_banks("R8 timeout clear", 2'b00, 2'b01, 2'b00, 2'b01);
    chk_cnts("R8 timeout counted");
    tick(5);
    chk_banks("R8 idle after clear", 2'b00, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic t_pingpong();
    l2_tmo_cycles = 200; clr_cycles = 5;
    pulse_l1();
    pulse_l1();
    chk_banks("R2 second trigger to bank1", 2'b11, 2'b00, 2'b00, 2'b11);
    chk("R3 fe_busy when all busy", 32'(fe_busy), 32'd1);
    pulse_l1();
    exp_drp++;
    chk_banks("R4 drop leaves banks", 2'b11, 2'b00, 2'b00, 2'b11);
    chk_cnts("R4 drop counted");
    tick(3);
    pulse_l2(1'b0);
    exp_clr++;
    chk_banks("R5 reject hits oldest bank0", 2'b00, 2'b01, 2'b00, 2'b11);
    pulse_l2(1'b1);
    exp_acc++;
    chk_banks("R5 accept hits bank1", 2'b00, 2'b01, 2'b10, 2'b11);
    pulse_l1();
    exp_drp++;
    chk_banks("R4 drop while clearing", 2'b00, 2'b01, 2'b10, 2'b11);
    chk_cnts("R4 second drop");
    tick(3);
    chk_banks("R3 one bank free", 2'b00, 2'b00, 2'b10, 2'b10);
    pulse_done(2'b10);
    chk_banks("R6 bank1 released", 2'b00, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic t_order();
    l2_tmo_cycles = 200; clr_cycles = 5;
    pulse_l1();
    pulse_l1();
    tick(4);
    pulse_l2(1'b0);
    exp_clr++;
    chk_banks("R5 bank0 cleared first", 2'b00, 2'b01, 2'b00, 2'b11);
    tick(5);
    chk_banks("R5 bank0 idle bank1 waits", 2'b00, 2'b00, 2'b00, 2'b10);
    pulse_l1();
    chk_banks("R2 lowest idle is bank0", 2'b01, 2'b00, 2'b00, 2'b11);
    pulse_l2(1'b1);
    exp_acc++;
    chk_banks("R5 older bank1 gets accept", 2'b01, 2'b00, 2'b10, 2'b11);
    chk_cnts("R5 counters after accept");
    pulse_l2(1'b0);
    exp_clr++;
    chk_banks("R5 then bank0 rejected", 2'b00, 2'b01, 2'b10, 2'b11);
    tick(5);
    chk_banks("R7 bank0 back to idle", 2'b00, 2'b00, 2'b10, 2'b10);
    pulse_done(2'b10);
    chk_banks("R6 all idle", 2'b00, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic t_idle_decision();
    pulse_l2(1'b1);
    pulse_l2(1'b0);
    chk_banks("R9 decision ignored", 2'b00, 2'b00, 2'b00, 2'b00);
    chk_cnts("R9 counters unchanged");
    tick(3);
    chk_banks("R9 still idle", 2'b00, 2'b00, 2'b00, 2'b00);
    chk_cnts("R9 counters still unchanged");
  endtask

  task automatic t_race();
    l2_tmo_cycles = 10; clr_cycles = 5;
    pulse_l1();
    tick(9);
    pulse_l2(1'b1);
    exp_acc++;
    chk_banks("R10 decision beats timeout", 2'b00, 2'b00, 2'b01, 2'b01);
    chk_cnts("R10 no clear counted");
    pulse_done(2'b01);
    chk_banks("R10 released", 2'b00, 2'b00, 2'b00, 2'b00);
  endtask

  initial begin
    rst_n = 1'b0;
    l1_accept = 1'b0;
    l2_valid = 1'b0;
    l2_pass = 1'b0;
    conv_done = '0;
    l2_tmo_cycles = 200;
    clr_cycles = 5;
    tick(3);
    t_reset();
    t_accept();
    tick(2);
    t_reject();
    tick(2);
    t_timeout();
    tick(2);
    t_pingpong();
    tick(2);
    t_order();
    tick(2);
    t_idle_decision();
    tick(2);
    t_race();
    tick(2);
    chk_cnts("final counters");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule